// File: doc/BRIEF.md
# Phase-Shedding PI Phase Regulator

This block closes the DC output voltage loop of a multi-cell boost rectifier in which cells can be switched off at light load. On every control sample it forms the voltage error, runs a proportional-integral law and produces a raw phase command. The raw phase is limited to a ceiling that scales with the number of cells currently running. The integrator stops growing in whichever direction would push further into that limit or below zero.

A second stage then multiplies the raw phase by the ratio of total cells to running cells. It uses a reciprocal constant computed at elaboration, so there is no divider. The product is limited again to the per-cell ceiling. Because of this stage, shedding or restoring cells changes the final command on the very next sample, without waiting for the integrator. Every stage saturates to its word width. Both outputs are registered and change only on a sample strobe.

Top module: `psh_pi_ctrl`

## Requirements
- R1: During and after reset, before the first sample strobe, `theta_raw`, `theta_fin` and the integrator are all 0.
- R2: With `sample_stb` low, both outputs hold their values whatever the other inputs do.
- R3: The error is `v_ref - v_meas`, saturated to VW signed bits. The proportional term is `(KP_Q*e) >>> GF` (floor), saturated to TW bits.
- R4: On each strobe the integrator adds `(KI_Q*e) >>> GF`, saturated to TW bits, unless R6 blocks the update. A positive error never lowers the integrator.
- R5: `theta_raw` is the saturated sum of the proportional term and the updated integrator, clamped to `[0, floor(n*CELL_MAX/NPH)]`, where n is the effective running-cell count.
- R6: If the pre-clamp sum (proportional term plus candidate integrator) exceeds the ceiling while the increment is positive, the integrator keeps its old value. The same applies if the sum is below 0 while the increment is negative. As a result the integrator stays within `[0, CELL_MAX]`.
- R7: `theta_fin = min(sat_TW((theta_raw*RC(n)) >>> RF), CELL_MAX)`, where `RC(n) = floor((NPH*2^RF + floor(n/2)) / n)`.
- R8: A `n_active` of 0, or a value greater than NPH, is treated as NPH.
- R9: A change of `n_active` takes effect on the same strobe for both the raw ceiling and the post-gain. With NPH=4, going from 4 running cells to 2 doubles `theta_fin` relative to `theta_raw`.
- R10: If the input difference goes beyond the VW-bit range, the error pins at the signed limit of that range and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_stb | input | 1 | One-cycle strobe that launches a control update |
| v_ref | input | VW | Signed voltage command |
| v_meas | input | VW | Signed sampled output voltage |
| n_active | input | NW | Count of running cells (NW = clog2(NPH+1)+1) |
| theta_raw | output | TW | Signed raw phase command after the running-count clamp |
| theta_fin | output | TW | Signed final phase after the NPH/n gain and the per-cell clamp |

## Verification
Two things can land on the same strobe: the anti-windup hold and a change in the running-cell count. The bench drives a large positive error until the raw phase sits at its ceiling with the integrator frozen. It then drops `n_active` from 4 to 2 while the error is still large. On that strobe the ceiling halves and the gain doubles, and the bench's scoreboard model predicts both the held integrator and the new final phase. Invalid counts, full-range inputs and an odd count whose reciprocal rounds are run through the same model. Idle cycles with changing inputs check that both outputs hold.

// File: rtl/psh_pkg.sv
package psh_pkg;

    typedef logic signed [63:0] wide_t;

    typedef enum logic [1:0] {
        SUM_INSIDE = 2'd0,
        SUM_ABOVE  = 2'd1,
        SUM_BELOW  = 2'd2
    } sum_zone_e;

    function automatic wide_t sat_bits(input wide_t x, input int unsigned w);
        wide_t hi;
        wide_t lo;
        hi = (64'sd1 <<< (w - 1)) - 64'sd1;
        lo = -(64'sd1 <<< (w - 1));
        if (x > hi)      return hi;
        else if (x < lo) return lo;
        else             return x;
    endfunction

    function automatic wide_t clamp_rng(input wide_t x, input wide_t lo, input wide_t hi);
        if (x > hi)      return hi;
        else if (x < lo) return lo;
        else             return x;
    endfunction

endpackage

// File: rtl/psh_limit_rom.sv
module psh_limit_rom #(
    parameter int NPH      = 4,
    parameter int NW       = 4,
    parameter int TW       = 16,
    parameter int RF       = 12,
    parameter int CELL_MAX = 8000,
    parameter int RCW      = 16
) (
    input  logic [NW-1:0]        n_in,
    output logic [NW-1:0]        n_eff,
    output logic signed [TW-1:0] raw_lim,
    output logic [RCW-1:0]       recip
);
    localparam logic [NW-1:0] N_TOP = NW'(NPH);

    logic signed [TW-1:0] lim_tab [1:NPH];
    logic [RCW-1:0]       rc_tab  [1:NPH];

    for (genvar k = 1; k <= NPH; k++) begin : g_tab
        localparam int LIM_K = (k * CELL_MAX) / NPH;
        localparam int RC_K  = ((NPH << RF) + (k / 2)) / k;
        assign lim_tab[k] = TW'(LIM_K);
        assign rc_tab[k]  = RCW'(RC_K);
    end

    always_comb begin
        n_eff = (n_in == '0 || n_in > N_TOP) ? N_TOP : n_in;
        raw_lim = lim_tab[NPH];
        recip   = rc_tab[NPH];
        for (int k = 1; k <= NPH; k++) begin
            if (n_eff == NW'(k)) begin
                raw_lim = lim_tab[k];
                recip   = rc_tab[k];
            end
        end
    end

endmodule

// File: rtl/psh_pi_core.sv
module psh_pi_core
    import psh_pkg::*;
#(
    parameter int VW   = 16,
    parameter int TW   = 16,
    parameter int GF   = 12,
    parameter int KP_Q = 2048,
    parameter int KI_Q = 410
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stb,
    input  logic signed [VW-1:0] err,
    input  logic signed [TW-1:0] lim,
    output logic signed [TW-1:0] raw_next,
    output logic signed [TW-1:0] acc_q
);
    typedef struct packed {
        logic signed [TW-1:0] acc;
    } core_t;

    core_t     st_d, st_q;
    wide_t     e_w, lim_w, acc_w, p_w, inc_w, cand_w, sum_w, keep_w;
    sum_zone_e zone;

    always_comb begin
        e_w    = {{(64-VW){err[VW-1]}}, err};
        lim_w  = {{(64-TW){lim[TW-1]}}, lim};
        acc_w  = {{(64-TW){st_q.acc[TW-1]}}, st_q.acc};
        p_w    = sat_bits((e_w * wide_t'(KP_Q)) >>> GF, TW);
        inc_w  = sat_bits((e_w * wide_t'(KI_Q)) >>> GF, TW);
        cand_w = sat_bits(acc_w + inc_w, TW);
        sum_w  = sat_bits(p_w + cand_w, TW);

        if (sum_w > lim_w)        zone = SUM_ABOVE;
        else if (sum_w < 64'sd0)  zone = SUM_BELOW;
        else                      zone = SUM_INSIDE;

        if ((zone == SUM_ABOVE && inc_w > 64'sd0) ||
            (zone == SUM_BELOW && inc_w < 64'sd0))
            keep_w = acc_w;
        else
            keep_w = cand_w;

        raw_next = TW'(clamp_rng(sat_bits(p_w + keep_w, TW), 64'sd0, lim_w));

        st_d = st_q;
        if (stb) st_d.acc = TW'(keep_w);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_q = st_q.acc;

endmodule

// File: rtl/psh_post_gain.sv
module psh_post_gain
    import psh_pkg::*;
#(
    parameter int TW       = 16,
    parameter int RF       = 12,
    parameter int RCW      = 16,
    parameter int CELL_MAX = 8000
) (
    input  logic signed [TW-1:0] raw,
    input  logic [RCW-1:0]       recip,
    output logic signed [TW-1:0] fin
);
    wide_t raw_w, rc_w, prod_w;

    always_comb begin
        raw_w  = {{(64-TW){raw[TW-1]}}, raw};
        rc_w   = {{(64-RCW){1'b0}}, recip};
        prod_w = sat_bits((raw_w * rc_w) >>> RF, TW);
        fin    = TW'(clamp_rng(prod_w, 64'sd0, wide_t'(CELL_MAX)));
    end

endmodule

// File: rtl/psh_pi_ctrl.sv
module psh_pi_ctrl
    import psh_pkg::*;
#(
    parameter int  NPH      = 4,
    parameter int  VW       = 16,
    parameter int  TW       = 16,
    parameter int  GF       = 12,
    parameter int  RF       = 12,
    parameter int  KP_Q     = 2048,
    parameter int  KI_Q     = 410,
    parameter int  CELL_MAX = 8000,
    localparam int NW       = $clog2(NPH + 1) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_stb,
    input  logic signed [VW-1:0] v_ref,
    input  logic signed [VW-1:0] v_meas,
    input  logic [NW-1:0]        n_active,
    output logic signed [TW-1:0] theta_raw,
    output logic signed [TW-1:0] theta_fin
);
    localparam int RCW = RF + NW + 1;

    typedef struct packed {
        logic signed [TW-1:0] raw;
        logic signed [TW-1:0] fin;
    } out_t;

    out_t                 out_d, out_q;
    logic signed [VW-1:0] err;
    logic [NW-1:0]        n_eff;
    logic signed [TW-1:0] raw_lim;
    logic [RCW-1:0]       recip;
    logic signed [TW-1:0] raw_next;
    logic signed [TW-1:0] fin_next;
    logic signed [TW-1:0] integ_q;
    wide_t                diff_w;

    always_comb begin
        diff_w = {{(64-VW){v_ref[VW-1]}}, v_ref} - {{(64-VW){v_meas[VW-1]}}, v_meas};
        err    = VW'(sat_bits(diff_w, VW));
    end

    psh_limit_rom #(
        .NPH(NPH), .NW(NW), .TW(TW), .RF(RF), .CELL_MAX(CELL_MAX), .RCW(RCW)
    ) u_rom (
        .n_in(n_active), .n_eff(n_eff), .raw_lim(raw_lim), .recip(recip)
    );

    psh_pi_core #(
        .VW(VW), .TW(TW), .GF(GF), .KP_Q(KP_Q), .KI_Q(KI_Q)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .stb(sample_stb), .err(err), .lim(raw_lim),
        .raw_next(raw_next), .acc_q(integ_q)
    );

    psh_post_gain #(
        .TW(TW), .RF(RF), .RCW(RCW), .CELL_MAX(CELL_MAX)
    ) u_gain (
        .raw(raw_next), .recip(recip), .fin(fin_next)
    );

    always_comb begin
        out_d = out_q;
        if (sample_stb) begin
            out_d.raw = raw_next;
            out_d.fin = fin_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign theta_raw = out_q.raw;
    assign theta_fin = out_q.fin;

endmodule

// File: rtl/psh_pi_ctrl_chk.sv
module psh_pi_ctrl_chk #(
    parameter int NPH      = 4,
    parameter int VW       = 16,
    parameter int TW       = 16,
    parameter int NW       = 4,
    parameter int CELL_MAX = 8000
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sample_stb,
    input logic signed [VW-1:0] v_ref,
    input logic signed [VW-1:0] v_meas,
    input logic [NW-1:0]        n_active,
    input logic signed [TW-1:0] theta_raw,
    input logic signed [TW-1:0] theta_fin,
    input logic signed [TW-1:0] integ_q
);
    function automatic int ceil_of(input logic [NW-1:0] n);
        int k;
        k = (n == '0 || int'(n) > NPH) ? NPH : int'(n);
        return (k * CELL_MAX) / NPH;
    endfunction

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> ($stable(theta_raw) && $stable(theta_fin)));

    assert_raw_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> (int'(theta_raw) >= 0 && int'(theta_raw) <= ceil_of($past(n_active))));

    assert_fin_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(theta_fin) >= 0 && int'(theta_fin) <= CELL_MAX));

    assert_integ_rises_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && v_ref > v_meas) |=> (integ_q >= $past(integ_q)));

    assert_integ_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(integ_q) >= 0 && int'(integ_q) <= CELL_MAX));

endmodule

bind psh_pi_ctrl psh_pi_ctrl_chk #(
    .NPH(NPH), .VW(VW), .TW(TW), .NW(NW), .CELL_MAX(CELL_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .v_ref(v_ref),
    .v_meas(v_meas), .n_active(n_active), .theta_raw(theta_raw),
    .theta_fin(theta_fin), .integ_q(integ_q)
);

// File: tb/psh_pi_ctrl_bench.sv
`timescale 1ns/1ps
module psh_pi_ctrl_bench;
    localparam int NPH = 4, VW = 16, TW = 16, GF = 12, RF = 12;
    localparam int KP_Q = 2048, KI_Q = 410, CELL_MAX = 8000;
    localparam int NW = $clog2(NPH + 1) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_stb = 1'b0;
    logic signed [VW-1:0] v_ref = '0, v_meas = '0;
    logic [NW-1:0] n_active = NW'(NPH);
    logic signed [TW-1:0] theta_raw, theta_fin;

    always #2 clk = ~clk;

    psh_pi_ctrl u_psh_pi_ctrl (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .v_ref(v_ref),
        .v_meas(v_meas), .n_active(n_active), .theta_raw(theta_raw),
        .theta_fin(theta_fin)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;
    longint m_acc = 0, last_raw = 0, last_fin = 0;
    longint q_raw[$], q_fin[$];
    string  q_tag[$];
    logic   seen = 1'b0;

    function automatic longint sat(input longint x, input int w);
        longint hi, lo;
        hi = (64'sd1 <<< (w - 1)) - 1;
        lo = -(64'sd1 <<< (w - 1));
        return (x > hi) ? hi : ((x < lo) ? lo : x);
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_sample(input int vr, input int vm, input int n, input string tag);
        longint e, p, inc, cand, sum, lim, rc, raw, fin;
        int k;
        k = (n == 0 || n > NPH) ? NPH : n;
        lim = (k * CELL_MAX) / NPH;
        rc  = ((longint'(NPH) << RF) + k / 2) / k;
        e    = sat(longint'(vr) - longint'(vm), VW);
        p    = sat((e * KP_Q) >>> GF, TW);
        inc  = sat((e * KI_Q) >>> GF, TW);
        cand = sat(m_acc + inc, TW);
        sum  = sat(p + cand, TW);
        if (!((sum > lim && inc > 0) || (sum < 0 && inc < 0))) m_acc = cand;
        raw = sat(p + m_acc, TW);
        raw = (raw > lim) ? lim : ((raw < 0) ? 0 : raw);
        fin = sat((raw * rc) >>> RF, TW);
        fin = (fin > CELL_MAX) ? CELL_MAX : ((fin < 0) ? 0 : fin);
        last_raw = raw;
        last_fin = fin;
        @(negedge clk);
        v_ref = VW'(vr);
        v_meas = VW'(vm);
        n_active = NW'(n);
        sample_stb = 1'b1;
        q_raw.push_back(raw);
        q_fin.push_back(fin);
        q_tag.push_back(tag);
        @(negedge clk);
        sample_stb = 1'b0;
    endtask

    always @(posedge clk) seen <= sample_stb && rst_n;

    always @(negedge clk) begin
        if (seen && q_raw.size() > 0) begin
            string t;
            t = q_tag.pop_front();
            check({t, " raw"}, longint'(theta_raw), q_raw.pop_front());
            check({t, " fin"}, longint'(theta_fin), q_fin.pop_front());
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset raw", longint'(theta_raw), 0);
        check("R1 reset fin", longint'(theta_fin), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset raw", longint'(theta_raw), 0);

        do_sample(1000, 900, 4, "R3 small error");
        do_sample(1000, 900, 4, "R4 integrate 2");
        do_sample(1000, 900, 4, "R4 integrate 3");
        do_sample(1000, 1200, 4, "R5 negative floor");
        do_sample(1000, 1100, 4, "R6 low hold");
        do_sample(1000, 950, 4, "R4 recover");
        for (int i = 0; i < 6; i++) do_sample(20000, 0, 4, "R6 high windup");
        do_sample(20000, 0, 2, "R9 shed to 2");
        do_sample(20000, 0, 1, "R9 shed to 1");
        do_sample(3000, 2000, 3, "R7 odd count");
        do_sample(3000, 2500, 4, "R9 restore 4");
        do_sample(3000, 2500, 0, "R8 zero count");
        do_sample(3000, 2500, 7, "R8 over count");
        do_sample(32767, -32768, 4, "R10 full range");
        do_sample(-32768, 32767, 2, "R10 full negative");
        do_sample(500, 0, 3, "R7 rounding");

        @(negedge clk);
        v_ref = 16'sd30000;
        v_meas = -16'sd30000;
        n_active = NW'(1);
        repeat (5) @(negedge clk);
        check("R2 idle raw", longint'(theta_raw), last_raw);
        check("R2 idle fin", longint'(theta_fin), last_fin);

        repeat (3) @(negedge clk);
        if (q_raw.size() != 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R2 scoreboard: actual %0d pending expected 0", q_raw.size());
        end
        finish_run();
    end

endmodule